// File: doc/BRIEF.md
# Isolated Cell Excitation and ADC Scan Sequencer

This block walks eight transformer-coupled cell channels once per timer tick. Each channel gets one slot. In a slot the block selects the channel's transformer through an external enable latch. It then runs a two-byte SPI frame with an 8-input serial converter. The first byte programs the converter's next input and returns the upper half of the previous result. The second byte is sent as zero and returns the lower half.

The transformer excitation line is switched on between the two bytes, so that the analog settling time overlaps the readout of the low byte. The line stays on for at least a run-time settling count and is dropped one cycle after chip select rises, which is the moment the converter starts its next conversion. The converter returns each result one slot late. For this reason the slot that reads channel j programs input j+1 and enables the transformer of input j+1, so every excitation lines up with the input being acquired. Each 16-bit result is written into an eight-entry register file that a reader accesses by address. A bus-busy input can suppress a whole scan, and per-channel lock inputs protect entries that are being read.

Top module: `exc_scan_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `spi_cs_n` is 1, `excite` is 0, `latch_stb` is 0, and every result entry reads 0.
- R2: The tick timer fires once every `tick_period` cycles (1 ms at the default `tick_period` of 200000 with a 200 MHz clock). A tick that finds the block idle starts a scan on the next cycle. When the scan is shorter than the period, scan starts are exactly `tick_period` cycles apart. A tick that arrives during a scan is ignored, so scan starts always fall on multiples of the period.
- R3: Slot j, counted from 0, puts a one-hot byte with only bit 7-((j+1) mod 8) set on `latch_data`. It raises `latch_stb` for one cycle and drops it again while `spi_cs_n` is still high. This gives the enable sequence 6,5,4,3,2,1,0,7.
- R4: The first byte sent in slot j is the configuration word for input c=(j+1) mod 8. That word is bit7=1, bit6=c[0], bits5:4=c[2:1], bits3:0=0100 (input 0 → 0x84, input 1 → 0xC4, … input 7 → 0xF4).
- R5: SCK idles low and runs at clk/(2·SPI_HALF). MOSI is sent MSB first and changes only on falling SCK edges. Each low period of `spi_cs_n` carries exactly 16 rising SCK edges, and the second byte is 0x00.
- R6: `excite` rises only after the 8th rising SCK edge of a frame, while `spi_cs_n` is low. It stays high for exactly max(S, 16·SPI_HALF+1)+1 cycles, where S is `settle_cycles`.
- R7: `excite` falls exactly one cycle after `spi_cs_n` rises.
- R8: The 16 bits received in slot j (first byte high, second byte low) are stored in entry j.
- R9: If `bus_busy` is high when a tick arrives, no scan runs for that tick: there is no strobe, no SPI frame, and no result changes.
- R10: If `rd_lock[j]` is high when slot j ends, entry j keeps its previous value.
- R11: `rd_data` shows the entry selected by `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_period | input | 20 | Scan timer period in clock cycles |
| settle_cycles | input | 12 | Minimum excitation on-time in cycles |
| bus_busy | input | 1 | Suppresses the scan for a tick that arrives while high |
| rd_lock | input | 8 | Per-entry write protection |
| rd_addr | input | 3 | Result read address |
| rd_data | output | 16 | Result at `rd_addr` |
| latch_data | output | 8 | One-hot transformer enable byte |
| latch_stb | output | 1 | Enable latch strobe |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data to converter |
| spi_miso | input | 1 | SPI data from converter |
| spi_cs_n | output | 1 | Converter select; its rising edge starts a conversion |
| excite | output | 1 | Shared transformer excitation |

## Verification
The strobe comes two cycles before `spi_cs_n` falls. The excitation rises in the cycle after the 16th edge of the first byte, and it falls in the cycle after `spi_cs_n` rises. A result entry can be read on the clock edge after that rise. The bench is an edge monitor that samples every output on the falling clock edge and keeps the previous sample, so each rise and fall is seen in the exact cycle the requirements place it. Width and delay checks compare cycle stamps against figures computed from `settle_cycles` and `SPI_HALF`. The result file is read only while the sequencer is idle between scans, against a converter model that builds each returned word from the configuration byte it decoded.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
    localparam int NUM_CH  = 8;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int BYTE_W  = 8;
    localparam int RES_W   = 2 * BYTE_W;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_STROBE,
        SQ_LATCHED,
        SQ_SELECT,
        SQ_HIBYTE,
        SQ_LOBYTE,
        SQ_RELEASE
    } seq_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } sample_t;

    // Input the converter is told to acquire during a given slot.
    function automatic logic [CH_W-1:0] acq_input(input logic [CH_W-1:0] slot);
        return slot + CH_W'(1);
    endfunction

    // Single-ended unipolar configuration byte for an input.
    function automatic logic [BYTE_W-1:0] cfg_byte(input logic [CH_W-1:0] inp);
        return {1'b1, inp[0], inp[2:1], 4'b0100};
    endfunction

    // One-hot transformer enable: bit order is mirrored against input number.
    function automatic logic [NUM_CH-1:0] enable_mask(input logic [CH_W-1:0] slot);
        logic [NUM_CH-1:0] m;
        m = '0;
        m[CH_W'(NUM_CH-1) - acq_input(slot)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/scan_tick_timer.sv
`timescale 1ns/1ps
module scan_tick_timer #(
    parameter int TICK_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TICK_W-1:0] period,
    output logic              tick
);
    localparam int CMP_W = TICK_W + 1;

    logic [TICK_W-1:0] cnt_q;
    logic              wrap;

    assign wrap = (CMP_W'(cnt_q) + CMP_W'(1)) >= CMP_W'(period);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + TICK_W'(1);
            tick  <= 1'b0;
        end
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && period > TICK_W'(1) && $stable(period)) |=> !tick);
endmodule

// File: rtl/spi_byte_engine.sv
`timescale 1ns/1ps
module spi_byte_engine #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic       busy,
    output logic [7:0] rx_byte
);
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);
    localparam logic [3:0] LAST_EDGE = 4'd15;

    logic [DIV_W-1:0] div_q;
    logic [3:0]       edge_q;
    logic [7:0]       tx_q;
    logic [7:0]       rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            edge_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            sck    <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    tx_q   <= tx_byte;
                    div_q  <= '0;
                    edge_q <= '0;
                    sck    <= 1'b0;
                end
            end else if (div_q == DIV_LAST) begin
                div_q  <= '0;
                sck    <= ~sck;
                edge_q <= edge_q + 4'd1;
                if (!sck) begin
                    rx_q <= {rx_q[6:0], miso};
                end else begin
                    tx_q <= {tx_q[6:0], 1'b0};
                end
                if (edge_q == LAST_EDGE) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    assign mosi    = tx_q[7];
    assign rx_byte = rx_q;

    // R5
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);
    // R5
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(mosi));
endmodule

// File: rtl/scan_result_file.sv
`timescale 1ns/1ps
module scan_result_file #(
    parameter int ENTRIES = 8,
    parameter int WIDTH   = 16,
    parameter int AW      = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [WIDTH-1:0]   wr_data,
    input  logic [ENTRIES-1:0] lock,
    input  logic [AW-1:0]      rd_addr,
    output logic [WIDTH-1:0]   rd_data
);
    logic [ENTRIES-1:0][WIDTH-1:0] mem;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (wr_en && wr_addr == AW'(g) && !lock[g]) begin
                mem[g] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lock[wr_addr]) |=> $stable(mem));
    // R8
    write_land_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !lock[wr_addr]) |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/exc_scan_seq.sv
`timescale 1ns/1ps
module exc_scan_seq
    import scan_pkg::*;
#(
    parameter int SPI_HALF = 2,
    parameter int TICK_W   = 20,
    parameter int SETTLE_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TICK_W-1:0]   tick_period,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                bus_busy,
    input  logic [NUM_CH-1:0]   rd_lock,
    input  logic [CH_W-1:0]     rd_addr,
    output logic [RES_W-1:0]    rd_data,
    output logic [NUM_CH-1:0]   latch_data,
    output logic                latch_stb,
    output logic                spi_sck,
    output logic                spi_mosi,
    input  logic                spi_miso,
    output logic                spi_cs_n,
    output logic                excite
);
    localparam int SC_W = SETTLE_W + 1;
    localparam logic [CH_W-1:0] LAST_SLOT = CH_W'(NUM_CH - 1);

    seq_state_t          state_q;
    logic [CH_W-1:0]     slot_q;
    logic [BYTE_W-1:0]   hi_q;
    logic [BYTE_W-1:0]   lo_q;
    logic                lo_seen_q;
    logic [SETTLE_W-1:0] settle_q;

    logic              tick;
    logic              spi_start;
    logic [BYTE_W-1:0] spi_tx;
    logic              spi_done;
    logic              spi_busy;
    logic [BYTE_W-1:0] spi_rx;
    logic              settled;
    logic              lo_ready;
    sample_t           sample;

    scan_tick_timer #(.TICK_W(TICK_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .period (tick_period),
        .tick   (tick)
    );

    assign spi_start = (state_q == SQ_SELECT) || (state_q == SQ_HIBYTE && spi_done);
    assign spi_tx    = (state_q == SQ_SELECT) ? cfg_byte(acq_input(slot_q)) : '0;

    spi_byte_engine #(.HALF(SPI_HALF)) u_spi (
        .clk     (clk),
        .rst     (rst),
        .start   (spi_start),
        .tx_byte (spi_tx),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .done    (spi_done),
        .busy    (spi_busy),
        .rx_byte (spi_rx)
    );

    assign settled  = (SC_W'(settle_q) + SC_W'(1)) >= SC_W'(settle_cycles);
    assign lo_ready = lo_seen_q || spi_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            slot_q    <= '0;
            hi_q      <= '0;
            lo_q      <= '0;
            lo_seen_q <= 1'b0;
            settle_q  <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (tick && !bus_busy) begin
                        state_q <= SQ_STROBE;
                        slot_q  <= '0;
                    end
                end
                SQ_STROBE:  state_q <= SQ_LATCHED;
                SQ_LATCHED: state_q <= SQ_SELECT;
                SQ_SELECT:  state_q <= SQ_HIBYTE;
                SQ_HIBYTE: begin
                    if (spi_done) begin
                        hi_q      <= spi_rx;
                        lo_seen_q <= 1'b0;
                        settle_q  <= '0;
                        state_q   <= SQ_LOBYTE;
                    end
                end
                SQ_LOBYTE: begin
                    if (settle_q != '1) begin
                        settle_q <= settle_q + SETTLE_W'(1);
                    end
                    if (spi_done) begin
                        lo_q      <= spi_rx;
                        lo_seen_q <= 1'b1;
                    end
                    if (lo_ready && settled) begin
                        state_q <= SQ_RELEASE;
                    end
                end
                SQ_RELEASE: begin
                    if (slot_q == LAST_SLOT) begin
                        state_q <= SQ_IDLE;
                    end else begin
                        slot_q  <= slot_q + CH_W'(1);
                        state_q <= SQ_STROBE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign sample = '{hi: hi_q, lo: lo_q};

    scan_result_file #(.ENTRIES(NUM_CH), .WIDTH(RES_W)) u_results (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (state_q == SQ_RELEASE),
        .wr_addr (slot_q),
        .wr_data (sample),
        .lock    (rd_lock),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign latch_data = (state_q == SQ_IDLE) ? '0 : enable_mask(slot_q);
    assign latch_stb  = (state_q == SQ_STROBE);
    assign spi_cs_n   = !(state_q == SQ_SELECT || state_q == SQ_HIBYTE ||
                          state_q == SQ_LOBYTE);
    assign excite     = (state_q == SQ_LOBYTE) || (state_q == SQ_RELEASE);

    // R7
    exc_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |=> !excite);
    // R6
    exc_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(excite) |-> !spi_cs_n);
    // R3
    stb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        latch_stb |-> ($countones(latch_data) == 1 && spi_cs_n));
    // R5
    cs_frame_chk: assert property (@(posedge clk) disable iff (rst)
        spi_busy |-> !spi_cs_n);
    // R9
    skip_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_IDLE && tick && bus_busy) |=> !latch_stb);
endmodule

// File: tb/exc_scan_seq_bench.sv
`timescale 1ns/1ps
module exc_scan_seq_bench;
    localparam int H      = 2;
    localparam int BYTE_T = 16 * H + 1;

    logic        clk = 1'b0;
    logic        rst;
    logic [19:0] tick_period;
    logic [11:0] settle_cycles;
    logic        bus_busy;
    logic [7:0]  rd_lock;
    logic [2:0]  rd_addr;
    logic [15:0] rd_data;
    logic [7:0]  latch_data;
    logic        latch_stb;
    logic        spi_sck;
    logic        spi_mosi;
    logic        spi_miso;
    logic        spi_cs_n;
    logic        excite;

    always #2.5 clk = ~clk;

    exc_scan_seq #(.SPI_HALF(H)) u_exc_scan_seq (
        .clk           (clk),
        .rst           (rst),
        .tick_period   (tick_period),
        .settle_cycles (settle_cycles),
        .bus_busy      (bus_busy),
        .rd_lock       (rd_lock),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .latch_data    (latch_data),
        .latch_stb     (latch_stb),
        .spi_sck       (spi_sck),
        .spi_mosi      (spi_mosi),
        .spi_miso      (spi_miso),
        .spi_cs_n      (spi_cs_n),
        .excite        (excite)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [7:0]  cfg_tab [8] = '{8'h84, 8'hC4, 8'h94, 8'hD4, 8'hA4, 8'hE4, 8'hB4, 8'hF4};
    logic [15:0] exp_res [8] = '{default: 16'h0};

    function automatic logic [2:0] decode_cfg(input logic [7:0] c);
        return {c[5], c[4], c[6]};
    endfunction

    // Monitor and converter model state
    logic        prev_sck, prev_cs, prev_exc, prev_stb;
    int          cyc = 0;
    int          stb_ctr = 0, slot_ctr = 0, scan_ctr = 0;
    int          bits = 0, last_rise_cyc = 0, cs_rise_cyc = 0, exc_cnt = 0;
    int          settle_cur = 2, period_cur = 800, gap_mode = 0;
    int          last_start_cyc = 0;
    bit          start_valid = 0, stb_in_slot = 0;
    logic [15:0] mo_sr = '0, miso_sh = '0, out_word = 16'hABCD;
    logic [31:0] conv_n = '0;

    always @(negedge clk) begin : monitor
        int nxt, slot, exp_w;
        cyc++;
        if (rst) begin
            prev_sck = spi_sck; prev_cs = spi_cs_n; prev_exc = excite; prev_stb = latch_stb;
        end else begin
            if (latch_stb && !prev_stb) begin
                nxt = ((stb_ctr % 8) + 1) % 8;
                check(latch_data == 8'(1 << (7 - nxt)), "R3 enable byte", latch_data, 8'(1 << (7 - nxt)));
                check(spi_cs_n == 1'b1, "R3 strobe before select", spi_cs_n, 1);
                stb_in_slot = 1;
                if (stb_ctr % 8 == 0) begin
                    if (start_valid && gap_mode == 1)
                        check(cyc - last_start_cyc == period_cur, "R2 scan spacing", cyc - last_start_cyc, period_cur);
                    if (start_valid && gap_mode == 2)
                        check((cyc - last_start_cyc) % period_cur == 0, "R2 ignored tick", cyc - last_start_cyc, period_cur);
                    last_start_cyc = cyc;
                    start_valid = 1;
                end
                stb_ctr++;
            end
            if (!spi_cs_n && prev_cs) begin
                check(stb_in_slot, "R3 strobe seen in slot", stb_in_slot, 1);
                bits = 0;
                mo_sr = '0;
                miso_sh = out_word;
                spi_miso = miso_sh[15];
            end
            if (spi_cs_n && spi_sck)
                check(0, "R5 sck idle low", spi_sck, 0);
            if (spi_sck && !prev_sck) begin
                mo_sr = {mo_sr[14:0], spi_mosi};
                if (bits != 0 && bits != 8)
                    check(cyc - last_rise_cyc == 2 * H, "R5 sck period", cyc - last_rise_cyc, 2 * H);
                bits++;
                last_rise_cyc = cyc;
            end
            if (!spi_sck && prev_sck && !spi_cs_n) begin
                miso_sh = miso_sh << 1;
                spi_miso = miso_sh[15];
            end
            if (excite && !prev_exc) begin
                check(!spi_cs_n && bits == 8, "R6 excitation after first byte", bits, 8);
                exc_cnt = 0;
            end
            if (excite) exc_cnt++;
            if (!excite && prev_exc) begin
                exp_w = ((settle_cur > BYTE_T) ? settle_cur : BYTE_T) + 1;
                check(exc_cnt == exp_w, "R6 excitation width", exc_cnt, exp_w);
                check(cyc == cs_rise_cyc + 1, "R7 excitation drop", cyc - cs_rise_cyc, 1);
            end
            if (spi_cs_n && !prev_cs) begin
                slot = slot_ctr % 8;
                check(mo_sr[15:8] == cfg_tab[(slot + 1) % 8], "R4 config byte", mo_sr[15:8], cfg_tab[(slot + 1) % 8]);
                check(mo_sr[7:0] == 8'h00, "R5 second byte zero", mo_sr[7:0], 0);
                check(bits == 16, "R5 edges per frame", bits, 16);
                if (!rd_lock[slot]) exp_res[slot] = out_word;
                out_word = {1'b0, decode_cfg(mo_sr[15:8]), conv_n[11:0]};
                conv_n++;
                cs_rise_cyc = cyc;
                slot_ctr++;
                stb_in_slot = 0;
                if (slot_ctr % 8 == 0) scan_ctr++;
            end
            prev_sck = spi_sck; prev_cs = spi_cs_n; prev_exc = excite; prev_stb = latch_stb;
        end
    end

    task automatic wait_scans(input int n);
        int target;
        target = scan_ctr + n;
        while (scan_ctr < target) @(negedge clk);
    endtask

    task automatic read_all(input string req);
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            rd_addr = 3'(j);
            #1;
            check(rd_data == exp_res[j], req, rd_data, exp_res[j]);
        end
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stimulus
        int s0;
        rst = 1'b1;
        tick_period = 20'd800;
        settle_cycles = 12'd2;
        bus_busy = 1'b0;
        rd_lock = '0;
        rd_addr = '0;
        spi_miso = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        check(excite == 1'b0, "R1 excite", excite, 0);
        check(latch_stb == 1'b0, "R1 strobe", latch_stb, 0);
        for (int j = 0; j < 8; j++) begin
            rd_addr = 3'(j);
            #1;
            check(rd_data == 16'h0, "R1 result cleared", rd_data, 0);
        end
        @(negedge clk);
        rst = 1'b0;

        // R2/R8/R11: regular scans, short settle
        gap_mode = 1;
        wait_scans(4);
        read_all("R8 stored result");

        // R10: locked entries hold
        rd_lock = 8'b0010_0100;
        wait_scans(1);
        read_all("R10 locked entry / R11 read");
        rd_lock = '0;

        // R9: busy tick skips the scan
        bus_busy = 1'b1;
        s0 = stb_ctr;
        repeat (period_cur + 20) @(negedge clk);
        check(stb_ctr == s0, "R9 skipped scan", stb_ctr - s0, 0);
        read_all("R9 results unchanged");
        bus_busy = 1'b0;
        start_valid = 0;

        // R6: long settle dominates the byte time
        settle_cycles = 12'd50;
        settle_cur = 50;
        wait_scans(1);
        read_all("R8 after long settle");

        // R2: ticks during a scan are ignored
        tick_period = 20'd100;
        period_cur = 100;
        gap_mode = 2;
        start_valid = 0;
        wait_scans(2);
        read_all("R8 short period");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule